// File: doc/BRIEF.md
# Write Strobe Qualifier with Power-On Lockout

This block sits between the already-synchronized control pins of a parallel flash part (chip enable, output enable, write enable) and the command decoder behind them. It turns the raw pin activity into a single-cycle write-accept pulse. That pulse carries the address and data captured when write enable returns high, and it is raised only when the write is legitimate.

Three conditions must hold for a write to count:

- Write enable must have been sampled low, with chip enable low and output enable high, for a minimum number of clock cycles. This rejects narrow glitches.
- At the rising edge of write enable, chip enable must still be low and output enable still high.
- A power-on lockout timer must have expired. The timer counts clock cycles while the digital supply-good flag is high. It restarts from zero whenever the flag drops.

The block also forms a qualified read enable, which is suppressed while the supply is not good. Both thresholds are parameters in clock cycles. With the defaults at a 125 MHz clock, the glitch limit is 2 cycles (16 ns, above a 15 ns minimum) and the lockout is 625000 cycles (5 ms).

Top module: `wrq_top`

## Requirements
- R1: After reset, `wr_pulse` is 0, `wr_addr` and `wr_data` are 0, `rd_en` is 0, and the lockout timer is at zero, so writes are refused.
- R2: The active condition is `we_n`=0, `ce_n`=0 and `oe_n`=1. A write-enable low period sampled on fewer than `MIN_LOW` consecutive clock edges in the active condition produces no pulse when `we_n` rises.
- R3: Suppose the active condition was sampled on at least `MIN_LOW` consecutive edges, and then an edge samples `we_n`=1 with `ce_n`=0, `oe_n`=1 and the lockout expired. After that edge, `wr_pulse` is 1 for exactly one cycle, and `wr_addr`/`wr_data` hold the `addr_in`/`data_in` sampled at that same edge.
- R4: Output enable low, whether at any sampled edge of the low period or at the rising edge, produces no pulse. A later write must again meet the full `MIN_LOW` count.
- R5: Chip enable high, whether at any sampled edge of the low period or at the rising edge, produces no pulse.
- R6: No pulse is produced while `supply_ok` is 0.
- R7: Writes are refused until `supply_ok` has been sampled high on `LOCK_CYC` consecutive edges. A rising edge that is the (`LOCK_CYC`+1)-th consecutive high sample or later may be accepted. The `LOCK_CYC`-th or earlier may not.
- R8: A single edge that samples `supply_ok`=0 restarts the lockout count from zero.
- R9: `rd_en` equals `ce_n`=0 and `oe_n`=0 and `supply_ok`=1 as sampled on the previous edge.
- R10: `wr_addr` and `wr_data` keep their values in every cycle without a pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ce_n | input | 1 | Synchronized chip enable, active low |
| oe_n | input | 1 | Synchronized output enable, active low |
| we_n | input | 1 | Synchronized write enable, active low |
| supply_ok | input | 1 | Digital supply-good flag |
| addr_in | input | AW | Address pins |
| data_in | input | DW | Data pins |
| wr_pulse | output | 1 | One-cycle write-accept pulse |
| wr_addr | output | AW | Address captured with the accepted write |
| wr_data | output | DW | Data captured with the accepted write |
| rd_en | output | 1 | Qualified read enable |

## Verification
Every output comes from exactly one register. The pulse and its captured address and data therefore appear one cycle after the edge that samples the rising write enable, and `rd_en` appears one cycle after the edge that samples the pins. The bench drives on falling edges and samples at the next falling edge, so it reads each result in the cycle it is due. It then reads the pulse again one cycle later to confirm the pulse has dropped. Lockout boundaries are counted in sampled edges from the falling edge where the supply is raised: 15 waiting cycles plus a 4-cycle low period must be refused, and 16 must be accepted.

// File: rtl/wrq_pkg.sv
`timescale 1ns/1ps
package wrq_pkg;

    typedef struct packed {
        logic ce_n;
        logic oe_n;
        logic we_n;
    } pins_t;

    typedef enum logic [1:0] {
        PH_IDLE  = 2'd0,
        PH_COUNT = 2'd1,
        PH_ARMED = 2'd2
    } phase_t;

    function automatic logic is_active(input pins_t p);
        return !p.we_n && !p.ce_n && p.oe_n;
    endfunction

endpackage

// File: rtl/wrq_we_filter.sv
`timescale 1ns/1ps
module wrq_we_filter #(
    parameter int MIN_LOW = 2
) (
    input  logic           clk,
    input  logic           rst_n,
    input  wrq_pkg::pins_t pins,
    output logic           rise_ok
);
    import wrq_pkg::*;

    localparam int FW = $clog2(MIN_LOW + 1);

    typedef struct packed {
        phase_t        phase;
        logic [FW-1:0] cnt;
    } st_t;

    st_t cur_q, nxt_d;
    logic act;

    always_comb begin
        nxt_d = cur_q;
        act   = is_active(pins);
        if (act) begin
            if (cur_q.phase != PH_ARMED) begin
                nxt_d.cnt   = cur_q.cnt + FW'(1);
                nxt_d.phase = (nxt_d.cnt >= FW'(MIN_LOW)) ? PH_ARMED : PH_COUNT;
            end
        end else begin
            nxt_d.cnt   = '0;
            nxt_d.phase = PH_IDLE;
        end
        rise_ok = (cur_q.phase == PH_ARMED) && pins.we_n && !pins.ce_n && pins.oe_n;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cur_q <= '{phase: PH_IDLE, cnt: '0};
        end else begin
            cur_q <= nxt_d;
        end
    end

    p_arm_needs_low_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (cur_q.phase == PH_ARMED) |-> $past(!pins.we_n));

    p_rise_disarms_r3: assert property (@(posedge clk) disable iff (!rst_n)
        rise_ok |=> (cur_q.phase == PH_IDLE));

    p_oe_aborts_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !pins.oe_n |=> (cur_q.phase == PH_IDLE));

endmodule

// File: rtl/wrq_lockout.sv
`timescale 1ns/1ps
module wrq_lockout #(
    parameter int LOCK_CYC = 625000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic supply_ok,
    output logic wr_enable
);
    localparam int CW = $clog2(LOCK_CYC + 1);

    typedef struct packed {
        logic [CW-1:0] cnt;
        logic          ready;
    } st_t;

    st_t cur_q, nxt_d;

    always_comb begin
        nxt_d = cur_q;
        if (!supply_ok) begin
            nxt_d.cnt   = '0;
            nxt_d.ready = 1'b0;
        end else if (!cur_q.ready) begin
            nxt_d.cnt   = cur_q.cnt + CW'(1);
            nxt_d.ready = (cur_q.cnt == CW'(LOCK_CYC - 1));
        end
        wr_enable = cur_q.ready && supply_ok;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cur_q <= '{cnt: '0, ready: 1'b0};
        end else begin
            cur_q <= nxt_d;
        end
    end

    p_drop_clears_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !supply_ok |=> (!cur_q.ready && cur_q.cnt == '0));

    p_ready_after_count_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cur_q.ready) |-> ($past(supply_ok) && $past(cur_q.cnt) == CW'(LOCK_CYC - 1)));

endmodule

// File: rtl/wrq_top.sv
`timescale 1ns/1ps
module wrq_top #(
    parameter int AW       = 18,
    parameter int DW       = 8,
    parameter int MIN_LOW  = 2,
    parameter int LOCK_CYC = 625000
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          ce_n,
    input  logic          oe_n,
    input  logic          we_n,
    input  logic          supply_ok,
    input  logic [AW-1:0] addr_in,
    input  logic [DW-1:0] data_in,
    output logic          wr_pulse,
    output logic [AW-1:0] wr_addr,
    output logic [DW-1:0] wr_data,
    output logic          rd_en
);
    import wrq_pkg::*;

    typedef struct packed {
        logic          pulse;
        logic [AW-1:0] addr;
        logic [DW-1:0] data;
        logic          rd;
    } out_t;

    pins_t pins;
    logic  rise_ok;
    logic  wr_enable;
    logic  accept;
    out_t  out_q, out_d;

    assign pins = '{ce_n: ce_n, oe_n: oe_n, we_n: we_n};

    wrq_we_filter #(.MIN_LOW(MIN_LOW)) u_filter (
        .clk     (clk),
        .rst_n   (rst_n),
        .pins    (pins),
        .rise_ok (rise_ok)
    );

    wrq_lockout #(.LOCK_CYC(LOCK_CYC)) u_lock (
        .clk       (clk),
        .rst_n     (rst_n),
        .supply_ok (supply_ok),
        .wr_enable (wr_enable)
    );

    always_comb begin
        out_d       = out_q;
        accept      = rise_ok && wr_enable;
        out_d.pulse = accept;
        if (accept) begin
            out_d.addr = addr_in;
            out_d.data = data_in;
        end
        out_d.rd = !ce_n && !oe_n && supply_ok;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_q <= '0;
        end else begin
            out_q <= out_d;
        end
    end

    assign wr_pulse = out_q.pulse;
    assign wr_addr  = out_q.addr;
    assign wr_data  = out_q.data;
    assign rd_en    = out_q.rd;

    p_pulse_single_r3: assert property (@(posedge clk) disable iff (!rst_n)
        wr_pulse |=> !wr_pulse);

    p_no_wr_low_supply_r6: assert property (@(posedge clk) disable iff (!rst_n)
        wr_pulse |-> $past(supply_ok));

    p_pins_at_rise_r5: assert property (@(posedge clk) disable iff (!rst_n)
        wr_pulse |-> ($past(oe_n) && !$past(ce_n) && $past(we_n)));

    p_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_pulse |-> ($stable(wr_addr) && $stable(wr_data)));

    p_read_gate_r9: assert property (@(posedge clk) disable iff (!rst_n)
        rd_en |-> $past(supply_ok));

endmodule

// File: tb/tb_wrq_top.sv
`timescale 1ns/1ps
module tb_wrq_top;
    localparam int AW = 18;
    localparam int DW = 8;
    localparam int ML = 4;
    localparam int LK = 20;

    logic clk = 1'b0;
    logic rst_n, ce_n, oe_n, we_n, supply_ok;
    logic [AW-1:0] addr_in, wr_addr;
    logic [DW-1:0] data_in, wr_data;
    logic wr_pulse, rd_en;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 0;

    always #4 clk = ~clk;

    wrq_top #(.AW(AW), .DW(DW), .MIN_LOW(ML), .LOCK_CYC(LK)) dut (
        .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .oe_n(oe_n), .we_n(we_n),
        .supply_ok(supply_ok), .addr_in(addr_in), .data_in(data_in),
        .wr_pulse(wr_pulse), .wr_addr(wr_addr), .wr_data(wr_data), .rd_en(rd_en)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // called at a falling edge; returns pulse at due cycle and one cycle later
    task automatic write_try(input int lowcyc, input logic ce_r, input logic oe_r,
                             input logic [AW-1:0] a, input logic [DW-1:0] d,
                             output logic p1, output logic p2);
        ce_n = 1'b0; oe_n = 1'b1; we_n = 1'b0;
        repeat (lowcyc) @(negedge clk);
        we_n = 1'b1; ce_n = ce_r; oe_n = oe_r; addr_in = a; data_in = d;
        @(negedge clk);
        p1 = wr_pulse;
        ce_n = 1'b1; oe_n = 1'b1; addr_in = '0; data_in = '0;
        @(negedge clk);
        p2 = wr_pulse;
    endtask

    // low a cycles, one cycle with a blocking pin, low b cycles, then rise
    task automatic abort_try(input bit use_oe, input int a, input int b, output logic p1);
        ce_n = 1'b0; oe_n = 1'b1; we_n = 1'b0;
        repeat (a) @(negedge clk);
        if (use_oe) oe_n = 1'b0; else ce_n = 1'b1;
        @(negedge clk);
        ce_n = 1'b0; oe_n = 1'b1;
        repeat (b) @(negedge clk);
        we_n = 1'b1; addr_in = 18'h3AAAA; data_in = 8'h99;
        @(negedge clk);
        p1 = wr_pulse;
        ce_n = 1'b1; addr_in = '0; data_in = '0;
        @(negedge clk);
    endtask

    task automatic dip_supply();
        supply_ok = 1'b0;
        @(negedge clk);
        supply_ok = 1'b1;
    endtask

    task automatic t_reset_and_boot();
        logic p1, p2;
        chk("R1 pulse", wr_pulse, 0);
        chk("R1 addr", wr_addr, 0);
        chk("R1 data", wr_data, 0);
        chk("R1 rd_en", rd_en, 0);
        write_try(ML, 1'b0, 1'b1, 18'h00111, 8'h11, p1, p2);
        chk("R1 locked at boot", p1, 0);
    endtask

    task automatic t_lock_boundary();
        logic p1, p2;
        dip_supply();
        repeat (LK - ML - 1) @(negedge clk);
        write_try(ML, 1'b0, 1'b1, 18'h00222, 8'h22, p1, p2);
        chk("R7 one edge early", p1, 0);
        dip_supply();
        repeat (LK - ML) @(negedge clk);
        write_try(ML, 1'b0, 1'b1, 18'h00333, 8'h33, p1, p2);
        chk("R7 exact boundary pulse", p1, 1);
        chk("R7 exact boundary addr", wr_addr, 18'h00333);
        repeat (30) @(negedge clk);
        dip_supply();
        repeat (LK - ML - 1) @(negedge clk);
        write_try(ML, 1'b0, 1'b1, 18'h00444, 8'h44, p1, p2);
        chk("R8 dip restarts timer", p1, 0);
        chk("R10 addr kept", wr_addr, 18'h00333);
        repeat (LK) @(negedge clk);
    endtask

    task automatic t_basic();
        logic p1, p2;
        write_try(ML, 1'b0, 1'b1, 18'h2BEEF, 8'hA5, p1, p2);
        chk("R3 pulse min low", p1, 1);
        chk("R3 addr", wr_addr, 18'h2BEEF);
        chk("R3 data", wr_data, 8'hA5);
        chk("R3 single cycle", p2, 0);
        write_try(ML + 5, 1'b0, 1'b1, 18'h01234, 8'h5A, p1, p2);
        chk("R3 pulse long low", p1, 1);
        chk("R3 addr long", wr_addr, 18'h01234);
        chk("R3 data long", wr_data, 8'h5A);
        chk("R3 single cycle long", p2, 0);
    endtask

    task automatic t_glitch();
        logic p1, p2;
        write_try(ML - 1, 1'b0, 1'b1, 18'h0F0F0, 8'h0F, p1, p2);
        chk("R2 short low", p1, 0);
        write_try(1, 1'b0, 1'b1, 18'h0F0F1, 8'hF0, p1, p2);
        chk("R2 one cycle low", p1, 0);
        chk("R10 addr held", wr_addr, 18'h01234);
        chk("R10 data held", wr_data, 8'h5A);
    endtask

    task automatic t_oe_ce();
        logic p1, p2;
        write_try(ML + 1, 1'b0, 1'b0, 18'h11111, 8'h01, p1, p2);
        chk("R4 oe low at rise", p1, 0);
        abort_try(1'b1, ML - 1, ML - 1, p1);
        chk("R4 oe low mid period", p1, 0);
        abort_try(1'b1, ML - 1, ML, p1);
        chk("R4 full count after oe", p1, 1);
        write_try(ML + 1, 1'b1, 1'b1, 18'h22222, 8'h02, p1, p2);
        chk("R5 ce high at rise", p1, 0);
        abort_try(1'b0, ML - 1, ML - 1, p1);
        chk("R5 ce high mid period", p1, 0);
    endtask

    task automatic t_supply_and_read();
        logic p1, p2;
        supply_ok = 1'b0;
        write_try(ML + 2, 1'b0, 1'b1, 18'h33333, 8'h03, p1, p2);
        chk("R6 no write low supply", p1, 0);
        ce_n = 1'b0; oe_n = 1'b0;
        @(negedge clk);
        chk("R9 read blocked low supply", rd_en, 0);
        supply_ok = 1'b1;
        @(negedge clk);
        chk("R9 read allowed", rd_en, 1);
        ce_n = 1'b1;
        @(negedge clk);
        chk("R9 read off ce high", rd_en, 0);
        ce_n = 1'b0; oe_n = 1'b1;
        @(negedge clk);
        chk("R9 read off oe high", rd_en, 0);
        ce_n = 1'b1;
        @(negedge clk);
    endtask

    initial begin
        rst_n = 1'b0; ce_n = 1'b1; oe_n = 1'b1; we_n = 1'b1;
        supply_ok = 1'b1; addr_in = '0; data_in = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset_and_boot();
        t_lock_boundary();
        t_basic();
        t_glitch();
        t_oe_ce();
        t_supply_and_read();
        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        #(8 * 100000);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end
endmodule